// File: doc/BRIEF.md
# Delay-Slot Branch Fetch Controller

This block drives the program counter and the fetch-to-decode pipeline register of a scalar, in-order, five-stage pipeline. In this pipeline exactly one instruction after every branch or jump always runs. An outside comparator resolves branches in the decode stage and reports a taken bit. By then the word at the branch address plus 4 has already been fetched. That word is the delay slot, so an ordinary branch only redirects the next fetch and discards nothing.

The block also handles three less common cases. A branch-likely that is not taken turns its delay slot into a no-op by clearing the valid bit of the fetch-to-decode register. A stall freezes both the PC and that register. If a branch resolves while the stall is active, its redirect is held and applied when the stall ends, so the delay slot is never lost. An exception request on the instruction in decode loads the exception vector and records a restart address. When the faulting instruction sits in a delay slot, the restart address is the branch address and a branch-delay status bit is set.

Top module: `dslot_fetch_ctrl`

## Requirements
- R1: During and right after a synchronous reset, the fetch PC equals the `RESET_VEC` parameter (default 0x100). The decode register is invalid, and the restart PC and branch-delay bit are 0.
- R2: In a cycle with no stall, no accepted exception and no branch redirect, the fetch PC advances by 4. The decode register takes the old fetch PC, marked valid and not in a slot.
- R3: A taken branch in a valid decode slot, with no stall, sets the next fetch PC to branch PC + 4 + (sign-extended 16-bit offset << 2). The already-fetched branch PC + 4 enters decode as valid, with its in-slot flag set.
- R4: A not-taken ordinary branch, and a taken branch-likely, behave as in R2 and R3 respectively. In both cases the delay slot enters decode valid.
- R5: A not-taken branch-likely lets the fetch PC advance by 4, but the delay slot enters decode with valid = 0.
- R6: A stall holds the fetch PC, the decode PC, the valid bit and the in-slot flag. A branch outcome seen during a stall is held and applied at the first cycle without a stall, even if the decode branch inputs have since dropped. The delay slot then enters decode valid.
- R7: An exception request on a valid decode instruction loads the fetch PC with the exception vector and invalidates decode. It wins over a branch or stall in the same cycle. When the instruction is not in a slot, the restart PC is its own PC and the branch-delay bit is 0. A request while decode is invalid is ignored.
- R8: An exception on a delay-slot instruction stores restart PC = its PC − 4, which is the branch address, and sets the branch-delay bit to 1.
- R9: `slot_branch_o` is 1 exactly when a branch is reported for a valid decode instruction whose in-slot flag is set.
- R10: A branch reported while decode is invalid has no effect. Fetch proceeds as in R2 and no in-slot flag follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze fetch PC and decode register |
| dec_branch_i | input | 1 | Decode instruction is a branch or jump |
| dec_likely_i | input | 1 | The branch is of the likely kind |
| dec_taken_i | input | 1 | Branch outcome from external comparator |
| dec_offset_i | input | 16 | Word offset of the branch |
| exc_req_i | input | 1 | Exception request for the decode instruction |
| exc_vector_i | input | 32 | Exception handler address |
| fetch_pc_o | output | 32 | Address being fetched |
| fd_valid_o | output | 1 | Decode register holds a live instruction |
| dec_pc_o | output | 32 | PC of the decode instruction |
| dec_in_slot_o | output | 1 | Decode instruction is a delay slot |
| slot_branch_o | output | 1 | Branch found inside a delay slot (undefined case) |
| epc_o | output | 32 | Saved restart PC |
| epc_bd_o | output | 1 | Saved instruction was in a delay slot |

## Verification
Bound assertions check several properties on every cycle. They check sequential advance, the branch target and the slot marking of a taken branch, and annulment on a not-taken likely branch. They also check that stalls freeze state, that the exception vector takes over, and that the restart PC moves back one word for a fault in a slot. Only the bench's scenarios can show the two-step behaviour of a redirect held across a stall, and that stale exception or branch requests on an invalid decode slot are ignored. They also cover the reset values and the mix of exceptions with stalls and branches under random stimulus. All of these are compared against a behavioural model.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned OFF_W       = 16;
    localparam int unsigned INSTR_BYTES = 4;
    localparam int unsigned SEXT_W      = ADDR_W - OFF_W - 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef struct packed {
        logic  valid;
        logic  taken;
        logic  likely;
        addr_t target;
    } redirect_t;

    typedef struct packed {
        logic  valid;
        logic  in_slot;
        addr_t pc;
    } fd_entry_t;

    function automatic addr_t branch_target(addr_t br_pc, off_t off);
        return br_pc + addr_t'(INSTR_BYTES) + {{SEXT_W{off[OFF_W-1]}}, off, 2'b00};
    endfunction

    function automatic addr_t restart_pc(addr_t pc, logic in_slot);
        return in_slot ? pc - addr_t'(INSTR_BYTES) : pc;
    endfunction
endpackage

// File: rtl/dsf_target_calc.sv
module dsf_target_calc
    import dsf_pkg::*;
(
    input  addr_t br_pc,
    input  off_t  offset,
    output addr_t target
);
    always_comb target = branch_target(br_pc, offset);
endmodule

// File: rtl/dsf_redirect_hold.sv
module dsf_redirect_hold
    import dsf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      stall,
    input  logic      flush,
    input  redirect_t live_rd,
    output redirect_t eff_rd,
    output logic      pend_valid
);
    redirect_t held_q;

    always_ff @(posedge clk) begin
        if (rst || flush || !stall) begin
            held_q <= '0;
        end else if (live_rd.valid && !held_q.valid) begin
            held_q <= live_rd;
        end
    end

    always_comb begin
        eff_rd     = held_q.valid ? held_q : live_rd;
        pend_valid = held_q.valid;
    end
endmodule

// File: rtl/dsf_epc_unit.sv
module dsf_epc_unit
    import dsf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  fd_entry_t cur,
    output addr_t     epc,
    output logic      bd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc <= '0;
            bd  <= 1'b0;
        end else if (take) begin
            epc <= restart_pc(cur.pc, cur.in_slot);
            bd  <= cur.in_slot;
        end
    end
endmodule

// File: rtl/dslot_fetch_ctrl.sv
module dslot_fetch_ctrl
    import dsf_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stall_i,
    input  logic        dec_branch_i,
    input  logic        dec_likely_i,
    input  logic        dec_taken_i,
    input  logic [15:0] dec_offset_i,
    input  logic        exc_req_i,
    input  logic [31:0] exc_vector_i,
    output logic [31:0] fetch_pc_o,
    output logic        fd_valid_o,
    output logic [31:0] dec_pc_o,
    output logic        dec_in_slot_o,
    output logic        slot_branch_o,
    output logic [31:0] epc_o,
    output logic        epc_bd_o
);
    addr_t     pc_q;
    fd_entry_t fd_q;
    addr_t     br_target;
    redirect_t live_rd, eff_rd;
    logic      pend_valid;
    logic      br_live, exc_take, annul, go_target;

    assign br_live  = dec_branch_i && fd_q.valid;
    assign exc_take = exc_req_i && fd_q.valid;

    dsf_target_calc u_tgt (
        .br_pc  (fd_q.pc),
        .offset (dec_offset_i),
        .target (br_target)
    );

    always_comb begin
        live_rd.valid  = br_live;
        live_rd.taken  = dec_taken_i;
        live_rd.likely = dec_likely_i;
        live_rd.target = br_target;
    end

    dsf_redirect_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .stall      (stall_i),
        .flush      (exc_take),
        .live_rd    (live_rd),
        .eff_rd     (eff_rd),
        .pend_valid (pend_valid)
    );

    assign annul     = eff_rd.valid && eff_rd.likely && !eff_rd.taken;
    assign go_target = eff_rd.valid && eff_rd.taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_VEC;
            fd_q <= '0;
        end else if (exc_take) begin
            pc_q <= exc_vector_i;
            fd_q <= '0;
        end else if (!stall_i) begin
            pc_q         <= go_target ? eff_rd.target : pc_q + addr_t'(INSTR_BYTES);
            fd_q.pc      <= pc_q;
            fd_q.valid   <= !annul;
            fd_q.in_slot <= eff_rd.valid && !annul;
        end
    end

    dsf_epc_unit u_epc (
        .clk  (clk),
        .rst  (rst),
        .take (exc_take),
        .cur  (fd_q),
        .epc  (epc_o),
        .bd   (epc_bd_o)
    );

    assign fetch_pc_o    = pc_q;
    assign fd_valid_o    = fd_q.valid;
    assign dec_pc_o      = fd_q.pc;
    assign dec_in_slot_o = fd_q.in_slot;
    assign slot_branch_o = br_live && fd_q.in_slot;
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker
    import dsf_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        stall_i,
    input logic        dec_branch_i,
    input logic        dec_likely_i,
    input logic        dec_taken_i,
    input logic [15:0] dec_offset_i,
    input logic        exc_req_i,
    input logic [31:0] exc_vector_i,
    input logic [31:0] fetch_pc_o,
    input logic        fd_valid_o,
    input logic [31:0] dec_pc_o,
    input logic        dec_in_slot_o,
    input logic        pend_valid
);
    logic live;
    always_ff @(posedge clk) live <= !rst;

    logic exc_ok;
    assign exc_ok = exc_req_i && fd_valid_o;

    // R2
    p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (live && !stall_i && !exc_ok && !pend_valid && !(dec_branch_i && fd_valid_o))
        |=> (fetch_pc_o == $past(fetch_pc_o) + 32'd4) && fd_valid_o && !dec_in_slot_o);

    // R3
    p_taken_target_r3: assert property (@(posedge clk) disable iff (rst)
        (live && !stall_i && !exc_ok && !pend_valid && fd_valid_o && dec_branch_i && dec_taken_i)
        |=> (fetch_pc_o == branch_target($past(dec_pc_o), $past(dec_offset_i)))
            && fd_valid_o && dec_in_slot_o);

    // R5
    p_likely_annul_r5: assert property (@(posedge clk) disable iff (rst)
        (live && !stall_i && !exc_ok && !pend_valid && fd_valid_o && dec_branch_i
         && dec_likely_i && !dec_taken_i)
        |=> !fd_valid_o && (fetch_pc_o == $past(fetch_pc_o) + 32'd4));

    // R6
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (live && stall_i && !exc_ok)
        |=> $stable(fetch_pc_o) && $stable(dec_pc_o) && $stable(fd_valid_o) && $stable(dec_in_slot_o));

    // R7
    p_exc_vector_r7: assert property (@(posedge clk) disable iff (rst)
        (live && exc_ok) |=> (fetch_pc_o == $past(exc_vector_i)) && !fd_valid_o);
endmodule

bind dslot_fetch_ctrl dsf_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .stall_i       (stall_i),
    .dec_branch_i  (dec_branch_i),
    .dec_likely_i  (dec_likely_i),
    .dec_taken_i   (dec_taken_i),
    .dec_offset_i  (dec_offset_i),
    .exc_req_i     (exc_req_i),
    .exc_vector_i  (exc_vector_i),
    .fetch_pc_o    (fetch_pc_o),
    .fd_valid_o    (fd_valid_o),
    .dec_pc_o      (dec_pc_o),
    .dec_in_slot_o (dec_in_slot_o),
    .pend_valid    (pend_valid)
);

// File: tb/tb_dslot_fetch_ctrl.sv
`timescale 1ns/1ps
module tb_dslot_fetch_ctrl;
    localparam logic [31:0] RV  = 32'h0000_0100;
    localparam logic [31:0] VEC = 32'h0000_0080;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stall_i = 0, dec_branch_i = 0, dec_likely_i = 0, dec_taken_i = 0, exc_req_i = 0;
    logic [15:0] dec_offset_i = '0;
    logic [31:0] exc_vector_i = VEC;
    logic [31:0] fetch_pc_o, dec_pc_o, epc_o;
    logic fd_valid_o, dec_in_slot_o, slot_branch_o, epc_bd_o;

    always #2.5 clk = ~clk;

    dslot_fetch_ctrl #(.RESET_VEC(RV)) dut (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // behavioural reference
    logic [31:0] m_pc, m_fpc, m_epc, m_ptgt;
    logic m_fv, m_fslot, m_bd, m_pv, m_ptk, m_plk;

    always @(posedge clk) begin
        logic br, use_t, ann, isbr;
        logic [31:0] tgt;
        if (rst) begin
            m_pc = RV; m_fpc = 0; m_fv = 0; m_fslot = 0; m_epc = 0; m_bd = 0; m_pv = 0;
        end else begin
            br  = dec_branch_i && m_fv;
            tgt = m_fpc + 32'd4 + {{14{dec_offset_i[15]}}, dec_offset_i, 2'b00};
            if (exc_req_i && m_fv) begin
                m_epc = m_fslot ? m_fpc - 32'd4 : m_fpc;
                m_bd = m_fslot; m_pc = exc_vector_i; m_fv = 0; m_fslot = 0; m_pv = 0; m_fpc = 0;
            end else if (stall_i) begin
                if (br && !m_pv) begin
                    m_pv = 1; m_ptk = dec_taken_i; m_plk = dec_likely_i; m_ptgt = tgt;
                end
            end else begin
                isbr  = m_pv || br;
                use_t = m_pv ? m_ptk : (br && dec_taken_i);
                ann   = m_pv ? (m_plk && !m_ptk) : (br && dec_likely_i && !dec_taken_i);
                if (m_pv) tgt = m_ptgt;
                m_fpc = m_pc; m_fv = !ann; m_fslot = isbr && !ann;
                m_pc = use_t ? tgt : m_pc + 32'd4;
                m_pv = 0;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk("R2 fetch_pc", fetch_pc_o, m_pc);
        chk("R5 fd_valid", {31'd0, fd_valid_o}, {31'd0, m_fv});
        if (m_fv) chk("R3 dec_pc", dec_pc_o, m_fpc);
        chk("R3 in_slot", {31'd0, dec_in_slot_o}, {31'd0, m_fslot});
        chk("R8 epc", epc_o, m_epc);
        chk("R8 bd", {31'd0, epc_bd_o}, {31'd0, m_bd});
    endtask

    task automatic step(bit br, bit lk, bit tk, logic [15:0] off, bit st, bit ex);
        dec_branch_i = br; dec_likely_i = lk; dec_taken_i = tk;
        dec_offset_i = off; stall_i = st; exc_req_i = ex;
        #1;
        total++;
        if (slot_branch_o !== (br && m_fv && m_fslot)) begin
            bad++;
            $display("FAIL R9 slot_branch actual=%b expected=%b", slot_branch_o, br && m_fv && m_fslot);
        end
        @(negedge clk);
        cmp_model();
    endtask

    task automatic nop(); step(0, 0, 0, 16'd0, 0, 0); endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc", fetch_pc_o, RV);
        chk("R1 valid", {31'd0, fd_valid_o}, 32'd0);
        chk("R1 epc", epc_o, 32'd0);
        chk("R1 bd", {31'd0, epc_bd_o}, 32'd0);
        rst = 0;
        nop();
        chk("R2 pc", fetch_pc_o, 32'h104);
        chk("R2 dec", dec_pc_o, 32'h100);
        nop();                                     // decode 0x104
        step(1, 0, 1, 16'd5, 0, 0);                // R3 taken
        chk("R3 target", fetch_pc_o, 32'h11C);
        chk("R3 slot pc", dec_pc_o, 32'h108);
        chk("R3 slot flag", {31'd0, dec_in_slot_o}, 32'd1);
        nop();                                     // decode 0x11C
        step(1, 1, 0, 16'd7, 0, 0);                // R5 likely not taken
        chk("R5 pc", fetch_pc_o, 32'h124);
        chk("R5 annulled", {31'd0, fd_valid_o}, 32'd0);
        nop();                                     // decode 0x124
        step(1, 0, 1, 16'hFFFE, 1, 0);             // R6 stall with taken branch
        chk("R6 hold pc", fetch_pc_o, 32'h128);
        chk("R6 hold dec", dec_pc_o, 32'h124);
        step(0, 0, 0, 16'd0, 1, 0);
        chk("R6 still held", fetch_pc_o, 32'h128);
        nop();
        chk("R6 deferred target", fetch_pc_o, 32'h120);
        chk("R6 slot kept", {31'd0, fd_valid_o}, 32'd1);
        step(0, 0, 0, 16'd0, 0, 1);                // R8 fault in slot 0x128
        chk("R8 epc", epc_o, 32'h124);
        chk("R8 bd", {31'd0, epc_bd_o}, 32'd1);
        chk("R7 vector", fetch_pc_o, VEC);
        step(0, 0, 0, 16'd0, 0, 1);                // R7 ignored, decode invalid
        chk("R7 ignored epc", epc_o, 32'h124);
        chk("R7 ignored pc", fetch_pc_o, 32'h84);
        step(1, 0, 1, 16'd9, 1, 1);                // R7 beats branch+stall
        chk("R7 priority pc", fetch_pc_o, VEC);
        chk("R7 epc", epc_o, 32'h80);
        chk("R7 bd", {31'd0, epc_bd_o}, 32'd0);
        step(1, 0, 1, 16'd10, 0, 0);               // R10 branch on invalid decode
        chk("R10 pc", fetch_pc_o, 32'h84);
        chk("R10 no slot", {31'd0, dec_in_slot_o}, 32'd0);
        step(1, 0, 1, 16'd1, 0, 0);                // decode 0x80 taken -> 0x88
        chk("R3 target2", fetch_pc_o, 32'h88);
        step(1, 0, 1, 16'd1, 0, 0);                // R9 branch in slot 0x84
        nop(); nop();
        step(1, 0, 0, 16'd40, 0, 0);               // R4 plain not taken
        chk("R4 not taken valid", {31'd0, fd_valid_o}, 32'd1);
        nop();
        step(1, 1, 1, 16'd2, 0, 0);                // R4 likely taken
        chk("R4 likely slot", {31'd0, dec_in_slot_o & fd_valid_o}, 32'd1);
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            step(r < 40, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                 16'($urandom_range(0, 65535)), $urandom_range(0, 3) == 0, r > 95);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule